// File: doc/BRIEF.md
# Cascadable 16-bit arithmetic/logic slice

This block is a purely combinational arithmetic/logic slice. It takes two operand words, a carry input and a three-bit function code, and returns a result word with a set of status flags. Eight function codes are supported:
- three additions: plain, with the first operand inverted, and with the second operand inverted;
- three bitwise operations;
- a forced all-zeros result and a forced all-ones result.

Subtraction in either direction uses one of the inverted-operand additions with the carry input held high.

For chaining slices into longer words, the slice reports its carry output, an overflow flag and active-low group propagate and group generate terms. An external lookahead unit can combine the group terms. The carry, overflow and group terms are computed only for the arithmetic codes. For every other code they rest at fixed inactive values. The zero flag is valid for every code.

Top module: `alu_slice16`

## Requirements
- R1: Function code 3'b000 drives every result bit to 0.
- R2: Function code 3'b111 drives every result bit to 1.
- R3: Function code 3'b011 gives result = (A + B + carry_in) modulo 2^16.
- R4: Function code 3'b001 gives result = (~A + B + carry_in) modulo 2^16, so that with carry_in = 1 the result equals B - A.
- R5: Function code 3'b010 gives result = (A + ~B + carry_in) modulo 2^16, so that with carry_in = 1 the result equals A - B.
- R6: Function codes 3'b100, 3'b101 and 3'b110 give A XOR B, A OR B and A AND B respectively, bit by bit.
- R7: For an arithmetic code, carry_out equals bit 16 of the 17-bit sum of the effective operands (the inverted operand where the code inverts one) plus carry_in.
- R8: For an arithmetic code, ovf_flag is 1 exactly when the carries into and out of bit 15 differ. This is the same as both effective operands sharing a sign bit that differs from the result's sign bit.
- R9: For an arithmetic code, grp_prop_n is the inverse of the AND over all bits of (x OR y). grp_gen_n is the inverse of the carry out of x + y with a zero carry in. Here x and y are the effective operands.
- R10: zero_flag is 1 exactly when all 16 result bits are 0, for every function code.
- R11: For codes 000, 100, 101, 110 and 111, carry_out and ovf_flag are 0, and grp_prop_n and grp_gen_n are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 for arithmetic codes |
| func_sel | input | 3 | Function code |
| result | output | 16 | Result word |
| zero_flag | output | 1 | High when the result is all zeros |
| ovf_flag | output | 1 | Signed overflow for arithmetic codes |
| carry_out | output | 1 | Carry out of bit 15 for arithmetic codes |
| grp_prop_n | output | 1 | Active-low group propagate |
| grp_gen_n | output | 1 | Active-low group generate |

## Verification
Carry-out and signed overflow can both be raised by the same operation. Both are provoked by operand pairs drawn from a corner set such as 0x8000, 0x7FFF and 0xFFFF, under each of the three additions with both carry-in values. The bench also judges the zero flag, which rises on wrap-around sums such as 0xFFFF + 1 in the same cycle as the carry. Each flag is compared separately against a reference built from a 17-bit sum and a sign-bit rule, so a slice that confuses the two flags fails at least one of those comparisons.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef enum logic [2:0] {
    FN_CLEAR  = 3'b000,
    FN_NAPLB  = 3'b001,
    FN_APLNB  = 3'b010,
    FN_ADD    = 3'b011,
    FN_XOR    = 3'b100,
    FN_OR     = 3'b101,
    FN_AND    = 3'b110,
    FN_PRESET = 3'b111
  } fn_e;

  function automatic logic fn_is_arith(input fn_e f);
    return (f == FN_NAPLB) || (f == FN_APLNB) || (f == FN_ADD);
  endfunction

  // one ripple step: carry out of a bit position
  function automatic logic carry_step(input logic g, input logic p, input logic c);
    return g | (p & c);
  endfunction

  // prefix combine of a lower group (gl,pl) under a higher bit (gh,ph)
  function automatic logic [1:0] gp_merge(input logic gh, input logic ph,
                                          input logic gl, input logic pl);
    return {gh | (ph & gl), ph & pl};
  endfunction

endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond
  import alu_slice_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  fn_e          fn,
  output logic [W-1:0] x_eff,
  output logic [W-1:0] y_eff
);
  logic inv_a, inv_b;

  assign inv_a = (fn == FN_NAPLB);
  assign inv_b = (fn == FN_APLNB);

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign x_eff[i] = a_in[i] ^ inv_a;
      assign y_eff[i] = b_in[i] ^ inv_b;
    end
  endgenerate
endmodule

// File: rtl/alu_carry_chain.sv
module alu_carry_chain
  import alu_slice_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic [W:0]   carry,
  output logic         grp_p,
  output logic         grp_g
);
  localparam int MSB = W - 1;

  logic [W-1:0] bit_g, bit_p, pre_g, pre_p;

  assign carry[0] = cin;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign bit_g[i]    = x[i] & y[i];
      assign bit_p[i]    = x[i] | y[i];
      assign carry[i+1]  = carry_step(bit_g[i], bit_p[i], carry[i]);
      assign sum[i]      = x[i] ^ y[i] ^ carry[i];
      if (i == 0) begin : g_first
        assign pre_g[0] = bit_g[0];
        assign pre_p[0] = bit_p[0];
      end else begin : g_rest
        assign {pre_g[i], pre_p[i]} = gp_merge(bit_g[i], bit_p[i], pre_g[i-1], pre_p[i-1]);
      end
    end
  endgenerate

  assign grp_p = pre_p[MSB];
  assign grp_g = pre_g[MSB];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_slice_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  fn_e          fn,
  output logic [W-1:0] lres
);
  always_comb begin
    case (fn)
      FN_XOR:  lres = a_in ^ b_in;
      FN_OR:   lres = a_in | b_in;
      FN_AND:  lres = a_in & b_in;
      default: lres = '0;
    endcase
  end
endmodule

// File: rtl/alu_slice16.sv
module alu_slice16
  import alu_slice_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [15:0] op_a,
  input  logic [15:0] op_b,
  input  logic        carry_in,
  input  logic [2:0]  func_sel,
  output logic [15:0] result,
  output logic        zero_flag,
  output logic        ovf_flag,
  output logic        carry_out,
  output logic        grp_prop_n,
  output logic        grp_gen_n
);
  localparam int MSB = W - 1;

  fn_e          fn;
  logic [W-1:0] x_eff, y_eff, sum_w, lres_w;
  logic [W:0]   carry_w;
  logic         grp_p_w, grp_g_w, arith_w;

  assign fn      = fn_e'(func_sel);
  assign arith_w = fn_is_arith(fn);

  alu_operand_cond #(.W(W)) u_cond (
    .a_in(op_a), .b_in(op_b), .fn(fn), .x_eff(x_eff), .y_eff(y_eff)
  );

  alu_carry_chain #(.W(W)) u_chain (
    .x(x_eff), .y(y_eff), .cin(carry_in), .sum(sum_w),
    .carry(carry_w), .grp_p(grp_p_w), .grp_g(grp_g_w)
  );

  alu_logic_unit #(.W(W)) u_logic (
    .a_in(op_a), .b_in(op_b), .fn(fn), .lres(lres_w)
  );

  always_comb begin
    case (fn)
      FN_CLEAR:                   result = '0;
      FN_PRESET:                  result = '1;
      FN_NAPLB, FN_APLNB, FN_ADD: result = sum_w;
      default:                    result = lres_w;
    endcase
  end

  assign zero_flag = ~|result;

  always_comb begin
    if (arith_w) begin
      carry_out  = carry_w[W];
      ovf_flag   = carry_w[W] ^ carry_w[MSB];
      grp_prop_n = ~grp_p_w;
      grp_gen_n  = ~grp_g_w;
    end else begin
      carry_out  = 1'b0;
      ovf_flag   = 1'b0;
      grp_prop_n = 1'b1;
      grp_gen_n  = 1'b1;
    end
  end

  // assertions beside the flag and result logic
  always_comb begin
    if (fn == FN_CLEAR)
      AST_CLEAR_ZERO: assert (zero_flag && result == '0) else $error("clear not zero"); // R1
    if (fn == FN_PRESET)
      AST_PRESET_ONES: assert (&result && !zero_flag) else $error("preset not ones"); // R2
    if (arith_w)
      AST_CARRY_LOOKAHEAD: assert (carry_out == (grp_g_w | (grp_p_w & carry_in))) else $error("ripple vs prefix"); // R7
    if (arith_w)
      AST_OVF_SIGN_RULE: assert (ovf_flag == ((x_eff[MSB] == y_eff[MSB]) && (result[MSB] != x_eff[MSB]))) else $error("overflow rule"); // R8
    if (!arith_w)
      AST_IDLE_FLAGS: assert (!carry_out && !ovf_flag && grp_prop_n && grp_gen_n) else $error("idle flags"); // R11
  end
endmodule

// File: tb/alu_slice16_tb.sv
module alu_slice16_tb_top;
  logic        clk = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic        carry_in = 1'b0;
  logic [2:0]  func_sel = 3'b000;
  logic [15:0] result;
  logic        zero_flag, ovf_flag, carry_out, grp_prop_n, grp_gen_n;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alu_slice16 dut_i (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .func_sel(func_sel),
    .result(result), .zero_flag(zero_flag), .ovf_flag(ovf_flag),
    .carry_out(carry_out), .grp_prop_n(grp_prop_n), .grp_gen_n(grp_gen_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (a=%h b=%h cin=%0d fn=%0d)", tag, act, exp, op_a, op_b, carry_in, func_sel);
    end
  endtask

  task automatic run_vec(input logic [2:0] f, input logic [15:0] a, input logic [15:0] b, input logic c);
    logic [15:0] x, y, e_res;
    logic [16:0] s17, g17;
    logic ar, e_co, e_ov, e_pn, e_gn;
    string rtag;
    @(posedge clk);
    op_a = a; op_b = b; carry_in = c; func_sel = f;
    ar = (f == 3'd1) || (f == 3'd2) || (f == 3'd3);
    x = (f == 3'd1) ? ~a : a;
    y = (f == 3'd2) ? ~b : b;
    s17 = {1'b0, x} + {1'b0, y} + {16'd0, c};
    g17 = {1'b0, x} + {1'b0, y};
    case (f)
      3'd0: begin e_res = 16'h0000; rtag = "R1 clear"; end
      3'd7: begin e_res = 16'hFFFF; rtag = "R2 preset"; end
      3'd3: begin e_res = s17[15:0]; rtag = "R3 add"; end
      3'd1: begin e_res = s17[15:0]; rtag = "R4 not-a plus b"; end
      3'd2: begin e_res = s17[15:0]; rtag = "R5 a plus not-b"; end
      3'd4: begin e_res = a ^ b; rtag = "R6 xor"; end
      3'd5: begin e_res = a | b; rtag = "R6 or"; end
      default: begin e_res = a & b; rtag = "R6 and"; end
    endcase
    e_co = ar ? s17[16] : 1'b0;
    e_ov = ar ? ((x[15] == y[15]) && (s17[15] != x[15])) : 1'b0;
    e_pn = ar ? ~(&(x | y)) : 1'b1;
    e_gn = ar ? ~g17[16] : 1'b1;
    @(negedge clk);
    chk(result == e_res, rtag, {16'd0, result}, {16'd0, e_res});
    chk(zero_flag == (e_res == 16'd0), "R10 zero", {31'd0, zero_flag}, {31'd0, e_res == 16'd0});
    chk(carry_out == e_co, ar ? "R7 carry" : "R11 idle carry", {31'd0, carry_out}, {31'd0, e_co});
    chk(ovf_flag == e_ov, ar ? "R8 overflow" : "R11 idle ovf", {31'd0, ovf_flag}, {31'd0, e_ov});
    chk({grp_prop_n, grp_gen_n} == {e_pn, e_gn}, ar ? "R9 group p/g" : "R11 idle p/g",
        {30'd0, grp_prop_n, grp_gen_n}, {30'd0, e_pn, e_gn});
  endtask

  task automatic sub_check(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] d;
    run_vec(3'd1, a, b, 1'b1);
    d = b - a;
    chk(result == d, "R4 b minus a", {16'd0, result}, {16'd0, d});
    run_vec(3'd2, a, b, 1'b1);
    d = a - b;
    chk(result == d, "R5 a minus b", {16'd0, result}, {16'd0, d});
  endtask

  logic [15:0] corners [8] = '{16'h0000, 16'hFFFF, 16'h0001, 16'h7FFF,
                               16'h8000, 16'h5555, 16'hAAAA, 16'h1234};

  initial begin
    // first state: clear with zero operands
    run_vec(3'd0, 16'h0000, 16'h0000, 1'b0);
    // wrap-around: all ones plus one, carry and zero together (R3, R7, R10)
    run_vec(3'd3, 16'hFFFF, 16'h0001, 1'b0);
    chk(zero_flag && carry_out && !ovf_flag, "R7 wrap carry+zero", {29'd0, zero_flag, carry_out, ovf_flag}, 32'd6);
    // signed overflow boundary (R8)
    run_vec(3'd3, 16'h7FFF, 16'h0001, 1'b0);
    chk(ovf_flag && !carry_out, "R8 pos overflow", {30'd0, ovf_flag, carry_out}, 32'd2);
    run_vec(3'd3, 16'h8000, 16'h8000, 1'b0);
    chk(ovf_flag && carry_out, "R8 neg overflow with carry", {30'd0, ovf_flag, carry_out}, 32'd3);
    sub_check(16'h0005, 16'h0003);
    sub_check(16'h8000, 16'h0001);
    sub_check(16'h1234, 16'h1234);
    for (int f = 0; f < 8; f++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int c = 0; c < 2; c++)
            run_vec(f[2:0], corners[i], corners[j], c[0]);
    for (int k = 0; k < 2000; k++)
      run_vec($urandom_range(7, 0), $urandom_range(16'hFFFF, 0), $urandom_range(16'hFFFF, 0), $urandom_range(1, 0));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule